// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins two open-drain data lines, one on the host side and one on the card side, so that a single half-duplex serial line can be carried across. Both lines rest high through external pull-ups. The block reads a sample of each line and, for each side, drives two enables: one that sinks the line low and one that pushes it high. The block never decides the direction ahead of time. Whichever side is seen to fall first becomes the master. After a fixed number of clock cycles the block pulls the other side, the slave, low. While that low is being copied, activity on the slave side is ignored.

When the master lets its line go, the block drives the slave side high for a short, fixed time so that the rising edge there is sharp. It then releases both sides. A new transfer can begin only after both lines read high again. An enable from the card activation sequencer holds the card line low and keeps the repeater idle while the card is not powered.

All timing is counted in cycles of the system clock. Both line samples first pass through a two-stage synchroniser. With the default parameters at 100 MHz, a host low reaches the card side within 110 ns and the pull-up pulse lasts 100 ns, which leaves enough margin for lines toggling at up to 1 MHz.

Top module: `od_line_repeater`

## Requirements
- R1: After reset, with `card_en` high and both lines high, all four drive enables are 0 (both lines released).
- R2: While `card_en` is 0, `card_drv_lo` is 1 and `card_drv_hi`, `host_drv_lo` and `host_drv_hi` are 0, whatever the lines do. Dropping `card_en` mid-transfer takes effect at once.
- R3: From the idle state, the first side whose sampled line reads 0 becomes master. If both fall in the same cycle, the host side wins.
- R4: A master low applied before clock edge 1 asserts the slave's drive-low enable after edge SYNC_STAGES+1+COPY_DLY (11 with defaults). The enable stays asserted while the master line stays low.
- R5: While one side is master, the master side's drive enables stay 0, and low pulses applied to the slave line have no effect on any enable.
- R6: A master release applied before edge 1 drops the slave drive-low enable and raises the slave drive-high enable after edge SYNC_STAGES+1 (3 with defaults). The drive-high enable stays asserted for exactly PULSE_LEN cycles.
- R7: After the pull-up pulse, all enables are 0. A new master is chosen only after both lines have read high; a line held low from during the pulse onward causes no copy until it is released.
- R8: A master low that lasts no more than COPY_DLY cycles is dropped. No slave drive-low or drive-high enable is asserted for it.
- R9: At most one of the four drive enables is asserted at any time while `card_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| card_en | input | 1 | Card side enabled by the activation sequencer (1 = enabled) |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_drv_lo | output | 1 | Sink the host line low |
| host_drv_hi | output | 1 | Push the host line high (pull-up pulse) |
| card_drv_lo | output | 1 | Sink the card line low |
| card_drv_hi | output | 1 | Push the card line high (pull-up pulse) |

## Verification
The assertions check the following on every cycle: that drives never overlap, that the card line is held low while the card is disabled, that each pull-up pulse follows a copied low on the same side, and that the pulse is exactly as wide as set. Other behaviours show up only in the bench scenarios, on wired-AND models of both lines. These are the exact copy and release latencies, host priority when both sides fall together, the lockout of slave-side pulses, the dropping of short glitches, and the rule that a new master waits until both lines read high.

// File: rtl/odr_pkg.sv
package odr_pkg;
  typedef enum logic [2:0] {
    ST_ARM    = 3'd0,  // wait until both lines read high
    ST_IDLE   = 3'd1,  // armed, watching for a first low
    ST_H_WAIT = 3'd2,  // host is master, copy delay running
    ST_H_LOW  = 3'd3,  // host is master, card side sunk low
    ST_H_PUSH = 3'd4,  // host released, card side pushed high
    ST_C_WAIT = 3'd5,
    ST_C_LOW  = 3'd6,
    ST_C_PUSH = 3'd7
  } odr_state_e;
endpackage

// File: rtl/odr_rst_sync.sv
module odr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], d[b]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
      end

      assign q[b] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/odr_timer.sv
module odr_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/odr_drive.sv
module odr_drive
  import odr_pkg::*;
(
  input  odr_state_e state,
  input  logic       card_en,
  output logic       host_drv_lo,
  output logic       host_drv_hi,
  output logic       card_drv_lo,
  output logic       card_drv_hi
);
  always_comb begin
    card_drv_lo = !card_en || (state == ST_H_LOW);
    card_drv_hi = card_en && (state == ST_H_PUSH);
    host_drv_lo = card_en && (state == ST_C_LOW);
    host_drv_hi = card_en && (state == ST_C_PUSH);
  end
endmodule

// File: rtl/od_line_repeater.sv
module od_line_repeater
  import odr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COPY_DLY    = 8,
  parameter int PULSE_LEN   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_en,
  input  logic host_in,
  input  logic card_in,
  output logic host_drv_lo,
  output logic host_drv_hi,
  output logic card_drv_lo,
  output logic card_drv_hi
);
  localparam int MAX_LEN = (COPY_DLY > PULSE_LEN) ? COPY_DLY : PULSE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] COPY_LOAD  = CNT_W'(COPY_DLY - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_LEN - 1);

  logic       rst_n_i;
  logic [1:0] line_s;
  logic       host_s;
  logic       card_s;
  odr_state_e state_q;
  odr_state_e state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  odr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  odr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({card_in, host_in}),
    .q     (line_s)
  );

  assign host_s = line_s[0];
  assign card_s = line_s[1];

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = COPY_LOAD;
    unique case (state_q)
      ST_ARM: begin
        if (host_s && card_s) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!host_s) begin
          state_d  = ST_H_WAIT;
          tmr_load = 1'b1;
        end else if (!card_s) begin
          state_d  = ST_C_WAIT;
          tmr_load = 1'b1;
        end
      end
      ST_H_WAIT: begin
        if (host_s)        state_d = ST_ARM;
        else if (tmr_zero) state_d = ST_H_LOW;
      end
      ST_H_LOW: begin
        if (host_s) begin
          state_d  = ST_H_PUSH;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LOAD;
        end
      end
      ST_H_PUSH: begin
        if (tmr_zero) state_d = ST_ARM;
      end
      ST_C_WAIT: begin
        if (card_s)        state_d = ST_ARM;
        else if (tmr_zero) state_d = ST_C_LOW;
      end
      ST_C_LOW: begin
        if (card_s) begin
          state_d  = ST_C_PUSH;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LOAD;
        end
      end
      ST_C_PUSH: begin
        if (tmr_zero) state_d = ST_ARM;
      end
      default: state_d = ST_ARM;
    endcase
    if (!card_en) begin
      state_d  = ST_ARM;
      tmr_load = 1'b0;
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_ARM;
    else          state_q <= state_d;
  end

  odr_timer #(.W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  odr_drive u_drv (
    .state       (state_q),
    .card_en     (card_en),
    .host_drv_lo (host_drv_lo),
    .host_drv_hi (host_drv_hi),
    .card_drv_lo (card_drv_lo),
    .card_drv_hi (card_drv_hi)
  );
endmodule

// File: rtl/odr_checker.sv
module odr_checker #(
  parameter int PULSE_LEN = 10
) (
  input logic clk,
  input logic rst_n,
  input logic card_en,
  input logic host_drv_lo,
  input logic host_drv_hi,
  input logic card_drv_lo,
  input logic card_drv_hi
);
  localparam int RW = $clog2(PULSE_LEN + 2);

  logic [RW-1:0] card_run;
  logic [RW-1:0] host_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_run <= '0;
      host_run <= '0;
    end else begin
      card_run <= card_drv_hi ? card_run + 1'b1 : '0;
      host_run <= host_drv_hi ? host_run + 1'b1 : '0;
    end
  end

  AST_CARD_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !card_en |-> (card_drv_lo && !card_drv_hi && !host_drv_lo && !host_drv_hi)); // R2

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    card_en |-> ($countones({host_drv_lo, host_drv_hi, card_drv_lo, card_drv_hi}) <= 1)); // R9

  AST_CARD_PUSH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(card_drv_hi)) |-> $past(card_drv_lo)); // R6

  AST_HOST_PUSH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_drv_hi)) |-> $past(host_drv_lo)); // R6

  AST_CARD_PUSH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    card_drv_hi |-> (card_run < RW'(PULSE_LEN))); // R6

  AST_CARD_PUSH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_drv_hi) && card_en) |-> (card_run == RW'(PULSE_LEN))); // R6

  AST_HOST_PUSH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(host_drv_hi) && card_en) |-> (host_run == RW'(PULSE_LEN))); // R6

  AST_RELEASE_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(card_drv_hi) && card_en) |-> (!card_drv_lo && !host_drv_lo && !host_drv_hi)); // R7
endmodule

bind od_line_repeater odr_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .card_en     (card_en),
  .host_drv_lo (host_drv_lo),
  .host_drv_hi (host_drv_hi),
  .card_drv_lo (card_drv_lo),
  .card_drv_hi (card_drv_hi)
);

// File: tb/od_line_repeater_tb.sv
module od_line_repeater_tb;
  localparam int SYNC  = 2;
  localparam int COPY  = 8;
  localparam int PULSE = 10;
  localparam int LAT_COPY = SYNC + 1 + COPY;
  localparam int LAT_REL  = SYNC + 1;

  logic clk;
  logic rst_n;
  logic card_en;
  logic host_pull;
  logic card_pull;
  logic host_in;
  logic card_in;
  logic host_drv_lo, host_drv_hi, card_drv_lo, card_drv_hi;

  int n_run;
  int n_fail;
  bit done;

  // wired-AND line models: any sink wins, else pulled or pushed high
  assign host_in = !(host_pull || host_drv_lo);
  assign card_in = !(card_pull || card_drv_lo);

  od_line_repeater #(.SYNC_STAGES(SYNC), .COPY_DLY(COPY), .PULSE_LEN(PULSE)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .card_en     (card_en),
    .host_in     (host_in),
    .card_in     (card_in),
    .host_drv_lo (host_drv_lo),
    .host_drv_hi (host_drv_hi),
    .card_drv_lo (card_drv_lo),
    .card_drv_hi (card_drv_hi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int drv_count();
    return int'(host_drv_lo) + int'(host_drv_hi) + int'(card_drv_lo) + int'(card_drv_hi);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // one transfer; from_host picks the master, tie pulls both sides together
  task automatic xfer(input bit from_host, input int hold, input bit poke, input bit tie);
    int first_lo;
    int first_hi;
    int width;
    int mst_bad;
    int lost;
    bit s_lo;
    bit s_hi;
    bit m_drv;
    first_lo = -1;
    first_hi = -1;
    width = 0;
    mst_bad = 0;
    lost = 0;
    @(negedge clk);
    if (from_host || tie) host_pull = 1'b1;
    if (!from_host || tie) card_pull = 1'b1;
    for (int n = 1; n <= hold; n++) begin
      @(posedge clk);
      @(negedge clk);
      s_lo  = from_host ? card_drv_lo : host_drv_lo;
      m_drv = from_host ? (host_drv_lo || host_drv_hi) : (card_drv_lo || card_drv_hi);
      if (m_drv) mst_bad++;
      if (s_lo && first_lo < 0) first_lo = n;
      if (first_lo >= 0 && !s_lo) lost++;
      if (tie && n == 2) begin
        card_pull = 1'b0;
      end
      if (poke && n == LAT_COPY + 2) begin
        if (from_host) card_pull = 1'b1; else host_pull = 1'b1;
      end
      if (poke && n == LAT_COPY + 4) begin
        if (from_host) card_pull = 1'b0; else host_pull = 1'b0;
      end
    end
    chk(first_lo == LAT_COPY, "R4 copy latency", first_lo, LAT_COPY);
    chk(lost == 0, "R4 slave low held", lost, 0);
    chk(mst_bad == 0, tie ? "R3 host wins tie" : "R5 master side undriven", mst_bad, 0);
    if (from_host) host_pull = 1'b0; else card_pull = 1'b0;
    for (int m = 1; m <= LAT_REL + PULSE + 3; m++) begin
      @(posedge clk);
      @(negedge clk);
      s_hi = from_host ? card_drv_hi : host_drv_hi;
      if (s_hi && first_hi < 0) first_hi = m;
      if (s_hi) width++;
    end
    chk(first_hi == LAT_REL, "R6 push start", first_hi, LAT_REL);
    chk(width == PULSE, "R6 push width", width, PULSE);
    chk(drv_count() == 0, "R7 released after push", drv_count(), 0);
    tick(3);
  endtask

  initial begin
    int hold;
    int cnt;
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    card_en = 1'b0;
    host_pull = 1'b0;
    card_pull = 1'b0;
    void'($urandom(32'd4242));
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // disabled card side
    chk(card_drv_lo && drv_count() == 1, "R2 card held low", drv_count(), 1);
    host_pull = 1'b1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (!card_drv_lo || drv_count() != 1) cnt++;
    end
    chk(cnt == 0, "R2 host traffic ignored while disabled", cnt, 0);
    host_pull = 1'b0;
    card_en = 1'b1;
    tick(6);
    chk(drv_count() == 0, "R1 idle released", drv_count(), 0);

    // directed transfers both ways, with slave pokes
    xfer(1'b1, LAT_COPY + 8, 1'b1, 1'b0);
    xfer(1'b0, LAT_COPY + 8, 1'b1, 1'b0);
    // tie: host wins
    xfer(1'b1, LAT_COPY + 6, 1'b0, 1'b1);

    // short glitch dropped
    host_pull = 1'b1;
    tick(3);
    host_pull = 1'b0;
    cnt = 0;
    for (int i = 0; i < LAT_COPY + PULSE + 4; i++) begin
      tick(1);
      if (drv_count() != 0) cnt++;
    end
    chk(cnt == 0, "R8 short host low dropped", cnt, 0);
    card_pull = 1'b1;
    tick(COPY);
    card_pull = 1'b0;
    cnt = 0;
    for (int i = 0; i < LAT_COPY + PULSE + 4; i++) begin
      tick(1);
      if (drv_count() != 0) cnt++;
    end
    chk(cnt == 0, "R8 short card low dropped", cnt, 0);

    // new master waits for both lines high
    host_pull = 1'b1;
    tick(LAT_COPY + 4);
    host_pull = 1'b0;
    tick(LAT_REL + 2);
    host_pull = 1'b1;
    cnt = 0;
    for (int i = 0; i < PULSE + 30; i++) begin
      tick(1);
      if (card_drv_lo || host_drv_lo) cnt++;
    end
    chk(cnt == 0, "R7 no copy until both high", cnt, 0);
    host_pull = 1'b0;
    tick(6);
    xfer(1'b0, LAT_COPY + 7, 1'b0, 1'b0);

    // enable dropped mid-transfer
    host_pull = 1'b1;
    tick(LAT_COPY + 3);
    card_en = 1'b0;
    tick(1);
    chk(card_drv_lo && drv_count() == 1, "R2 disable mid-transfer", drv_count(), 1);
    host_pull = 1'b0;
    tick(3);
    card_en = 1'b1;
    tick(6);
    chk(drv_count() == 0, "R1 idle after re-enable", drv_count(), 0);

    // random traffic
    for (int k = 0; k < 40; k++) begin
      hold = LAT_COPY + 6 + int'($urandom % 30);
      xfer(1'($urandom), hold, 1'($urandom), 1'b0);
      tick(int'($urandom % 5));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule